// File: doc/BRIEF.md
# Scoreboard-Gated Issue Controller

This block sits at the issue point of one in-order instruction stream. Each incoming instruction carries a compiler-built control word. The control word gives a stall count, a set of dependency slots the instruction must wait on, optional slots it claims for its own result or for a shared-memory read, and a hint that the warp selector may switch streams. The controller takes one instruction at a time through a valid/ready handshake. It holds the instruction until its stall count has run out and every slot named in its wait mask has no outstanding work. It then issues the instruction for one cycle and records the slots the instruction claims.

The block keeps six dependency slots. Each slot has a small outstanding counter. Issuing an instruction that claims a slot adds one to that slot's counter. A pulse on the completion input for that slot takes one away. A slot blocks a waiting instruction while its counter is not zero. A completion that reaches a slot with nothing outstanding is reported on an error output.

The sequencing is a three-state machine:
- **ST_IDLE** accepts a word. It goes to **ST_STALL** when the stall count is non-zero and to **ST_WAIT** when it is zero.
- **ST_STALL** counts the stall down. It goes to **ST_WAIT** on its last counted cycle.
- **ST_WAIT** issues the instruction once the named slots are clear, then returns to **ST_IDLE**.

The yield hint is passed through with the issue and has no effect on timing.

Top module: `issue_gate`

## Requirements
- R1: After reset, in_ready is 1, issue_valid is 0 and done_err is 0, and all six slot counters are zero.
- R2: Control word layout: stall count in bits [3:0], yield in bit 4, write slot in bits [7:5], read slot in bits [10:8], wait mask in bits [16:11]. When no slot blocks, issue_valid is high in the cycle that comes exactly stall cycles after the first cycle following the accepting edge. A stall of 0 therefore issues in that first cycle.
- R3: A write-slot value from 0 to 5 makes that slot pending when the instruction issues. A later instruction whose wait mask has that slot's bit set does not issue until a completion pulse for the slot has been sampled. It issues in the cycle after that edge if its stall has elapsed.
- R4: Slot field values 6 and 7 mean "none". An instruction with both fields set to none leaves every slot clear, so a following instruction that waits on all six slots issues after its stall alone.
- R5: Issue requires only the slots named in the wait mask to be clear. Pending slots outside the mask do not delay issue.
- R6: The read-slot field uses the same six slots, counters and wait-mask check as the write-slot field.
- R7: Each slot counts outstanding claims up to 7. Two claims need two completion pulses before the slot is clear. A claim and a completion on the same slot in the same cycle cancel, leaving the count unchanged.
- R8: done_err is high in any cycle in which a completion pulse hits a slot whose count is zero and which receives no claim in that cycle.
- R9: A completion that arrives before the stall has run out never shortens the stall. The issue cycle is the later of the stall-derived cycle and the cycle after the last needed completion.
- R10: in_ready is high only in ST_IDLE. issue_valid lasts exactly one cycle per accepted instruction. During issue, issue_ctrl shows the accepted word and issue_yield equals its bit 4. The yield bit never changes issue timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A control word is offered |
| in_ready | output | 1 | Controller can take a control word |
| in_ctrl | input | 17 | Control word of the offered instruction |
| done_pulse | input | 6 | One bit per slot, completion of one outstanding claim |
| issue_valid | output | 1 | Held instruction issues in this cycle |
| issue_yield | output | 1 | Stream-switch hint of the issuing instruction |
| issue_ctrl | output | 17 | Control word of the issuing instruction |
| done_err | output | 1 | Completion seen on a slot with nothing outstanding |

## Verification
Two functions can fall in the same cycle. One is the issue of a producer that claims a slot. The other is a completion pulse for that same slot. The bench provokes this by raising the completion pulse in the very cycle a second claimant on an already pending slot shows issue_valid. It then judges the outcome at the ports: done_err must stay low, and a later waiter must still need exactly one further completion before it issues. It also overlaps a pending stall countdown with an early completion and checks that the issue cycle is set by the stall, not by the completion.

// File: rtl/issue_pkg.sv
package issue_pkg;
    localparam int NUM_SLOTS = 6;
    localparam int SLOT_W    = 3;
    localparam int STALL_W   = 4;
    localparam int CNT_W     = 3;
    localparam int CTRL_W    = NUM_SLOTS + 2 * SLOT_W + 1 + STALL_W;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] wait_mask;
        logic [SLOT_W-1:0]    rd_slot;
        logic [SLOT_W-1:0]    wr_slot;
        logic                 yield;
        logic [STALL_W-1:0]   stall;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_WAIT  = 2'd2
    } state_t;
endpackage

// File: rtl/isg_slot_decode.sv
module isg_slot_decode #(
    parameter int NUM = 6,
    parameter int W   = 3
) (
    input  logic [W-1:0]   sel,
    input  logic           en,
    output logic [NUM-1:0] onehot
);
    // Values at or above NUM select no slot.
    for (genvar i = 0; i < NUM; i++) begin : g_dec
        assign onehot[i] = en && (sel == W'(i));
    end
endmodule

// File: rtl/isg_stall_timer.sv
module isg_stall_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign last = (count_q == W'(1));
endmodule

// File: rtl/isg_slot_bank.sv
module isg_slot_bank #(
    parameter int NUM = 6,
    parameter int CW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] claim_a,
    input  logic [NUM-1:0] claim_b,
    input  logic [NUM-1:0] done,
    output logic [NUM-1:0] busy,
    output logic [NUM-1:0] err_vec
);
    localparam int SW = CW + 2;
    localparam logic [SW-1:0] MAXV = SW'((1 << CW) - 1);

    for (genvar i = 0; i < NUM; i++) begin : g_slot
        logic [CW-1:0] cnt_q;
        logic [SW-1:0] base;
        logic [SW-1:0] after;
        logic [CW-1:0] cnt_d;

        always_comb begin
            base  = SW'(cnt_q) + SW'(claim_a[i]) + SW'(claim_b[i]);
            after = base;
            if (done[i] && base != '0) begin
                after = base - 1'b1;
            end
            cnt_d = (after > MAXV) ? MAXV[CW-1:0] : after[CW-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign busy[i]    = (cnt_q != '0);
        assign err_vec[i] = done[i] && (base == '0);
    end
endmodule

// File: rtl/issue_gate.sv
module issue_gate
    import issue_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [CTRL_W-1:0]    in_ctrl,
    input  logic [NUM_SLOTS-1:0] done_pulse,
    output logic                 issue_valid,
    output logic                 issue_yield,
    output logic [CTRL_W-1:0]    issue_ctrl,
    output logic                 done_err
);
    state_t state_q, state_d;
    ctrl_t  word_q;
    ctrl_t  in_word;
    logic   accept;
    logic   stall_last;
    logic   slots_clear;
    logic   fire;
    logic [NUM_SLOTS-1:0] slot_busy;
    logic [NUM_SLOTS-1:0] claim_wr;
    logic [NUM_SLOTS-1:0] claim_rd;
    logic [NUM_SLOTS-1:0] err_vec;

    assign in_word     = ctrl_t'(in_ctrl);
    assign accept      = in_valid && (state_q == ST_IDLE);
    assign slots_clear = ((word_q.wait_mask & slot_busy) == '0);
    assign fire        = (state_q == ST_WAIT) && slots_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= in_word;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = (in_word.stall == '0) ? ST_WAIT : ST_STALL;
                end
            end
            ST_STALL: begin
                if (stall_last) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (slots_clear) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready    = 1'b0;
        issue_valid = 1'b0;
        issue_yield = 1'b0;
        issue_ctrl  = '0;
        unique case (state_q)
            ST_IDLE:  in_ready = 1'b1;
            ST_STALL: ;
            ST_WAIT: begin
                issue_valid = slots_clear;
                issue_yield = slots_clear && word_q.yield;
                issue_ctrl  = slots_clear ? word_q : '0;
            end
            default: ;
        endcase
    end

    isg_stall_timer #(.W(STALL_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (in_word.stall),
        .dec      (state_q == ST_STALL),
        .last     (stall_last)
    );

    isg_slot_decode #(.NUM(NUM_SLOTS), .W(SLOT_W)) u_dec_wr (
        .sel    (word_q.wr_slot),
        .en     (fire),
        .onehot (claim_wr)
    );

    isg_slot_decode #(.NUM(NUM_SLOTS), .W(SLOT_W)) u_dec_rd (
        .sel    (word_q.rd_slot),
        .en     (fire),
        .onehot (claim_rd)
    );

    isg_slot_bank #(.NUM(NUM_SLOTS), .CW(CNT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .claim_a (claim_wr),
        .claim_b (claim_rd),
        .done    (done_pulse),
        .busy    (slot_busy),
        .err_vec (err_vec)
    );

    assign done_err = |err_vec;
endmodule

// File: rtl/issue_gate_chk.sv
module issue_gate_chk
    import issue_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [CTRL_W-1:0]    in_ctrl,
    input logic [NUM_SLOTS-1:0] done_pulse,
    input logic                 issue_valid,
    input logic [CTRL_W-1:0]    issue_ctrl,
    input logic                 done_err,
    input logic [NUM_SLOTS-1:0] slot_busy
);
    logic [4:0]         since_q;
    logic [STALL_W-1:0] stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            stall_q <= '0;
        end else if (in_valid && in_ready) begin
            since_q <= '0;
            stall_q <= in_ctrl[STALL_W-1:0];
        end else if (since_q != 5'd31) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_STALL_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (since_q >= 5'(stall_q))); // R9

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((issue_ctrl[CTRL_W-1 -: NUM_SLOTS] & slot_busy) == '0)); // R5

    AST_NOT_READY_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !in_ready); // R10

    AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid); // R10

    AST_ERR_NEEDS_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> ((done_pulse & ~slot_busy) != '0)); // R8

    AST_CLAIM_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ctrl[7:5] < 3'd6 && !done_pulse[issue_ctrl[7:5]])
        |=> slot_busy[$past(issue_ctrl[7:5])]); // R3
endmodule

bind issue_gate issue_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_ctrl     (in_ctrl),
    .done_pulse  (done_pulse),
    .issue_valid (issue_valid),
    .issue_ctrl  (issue_ctrl),
    .done_err    (done_err),
    .slot_busy   (slot_busy)
);

// File: tb/test_issue_gate.sv
module test_issue_gate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [16:0] in_ctrl = '0;
    logic [5:0]  done_pulse = '0;
    logic        issue_valid;
    logic        issue_yield;
    logic [16:0] issue_ctrl;
    logic        done_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [16:0] seen_ctrl;
    logic        seen_yield;

    always #(CLK_PERIOD / 2) clk = ~clk;

    issue_gate i_issue_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_ctrl     (in_ctrl),
        .done_pulse  (done_pulse),
        .issue_valid (issue_valid),
        .issue_yield (issue_yield),
        .issue_ctrl  (issue_ctrl),
        .done_err    (done_err)
    );

    function automatic logic [16:0] mk(input int mask, input int rd, input int wr,
                                       input int y, input int st);
        return {6'(mask), 3'(rd), 3'(wr), 1'(y), 4'(st)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer a word, return cycles from first post-accept cycle to issue.
    // Optionally pulses completions in the issue cycle.
    task automatic run_instr(input logic [16:0] w, input logic [5:0] d_at_issue,
                             output int lat);
        @(negedge clk);
        in_valid = 1'b1;
        in_ctrl  = w;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!issue_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        seen_ctrl  = issue_ctrl;
        seen_yield = issue_yield;
        done_pulse = d_at_issue;
        #1;
        if (d_at_issue != '0) chk(done_err == 1'b0, "R7", int'(done_err), 0);
        @(posedge clk);
        #1;
        done_pulse = '0;
    endtask

    // Offer a gated word; pulse done on slot sl ndone times, each after hold idle cycles.
    task automatic run_gated(input logic [16:0] w, input int sl, input int ndone,
                             input int hold, output int lat);
        @(negedge clk);
        in_valid = 1'b1;
        in_ctrl  = w;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        for (int k = 0; k < ndone; k++) begin
            for (int h = 0; h < hold; h++) begin
                chk(!issue_valid && !in_ready, "R3", int'(issue_valid), 0);
                @(negedge clk);
                lat++;
            end
            done_pulse = 6'(1 << sl);
            @(posedge clk);
            #1;
            done_pulse = '0;
            @(negedge clk);
            lat++;
        end
        while (!issue_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lat;
        int exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
        chk(issue_valid == 1'b0, "R1", int'(issue_valid), 0);
        chk(done_err == 1'b0, "R1", int'(done_err), 0);
        rst_n = 1'b1;

        // R1: slots clear after reset, all-slot waiter issues at once
        run_instr(mk(63, 7, 7, 0, 0), '0, lat);
        chk(lat == 0, "R1", lat, 0);

        // R2 / R10: stall sweep with both yield values
        for (int st = 0; st < 16; st++) begin
            for (int y = 0; y < 2; y++) begin
                run_instr(mk(0, 7, 7, y, st), '0, lat);
                chk(lat == st, "R2", lat, st);
                chk(seen_yield == 1'(y), "R10", int'(seen_yield), y);
                chk(seen_ctrl == mk(0, 7, 7, y, st), "R10", int'(seen_ctrl),
                    int'(mk(0, 7, 7, y, st)));
            end
        end

        // R3 / R6: each slot via write field, then via read field
        for (int kind = 0; kind < 2; kind++) begin
            for (int s = 0; s < 6; s++) begin
                if (kind == 0) run_instr(mk(0, 7, s, 0, 0), '0, lat);
                else           run_instr(mk(0, s, 7, 0, 0), '0, lat);
                chk(lat == 0, kind == 0 ? "R3" : "R6", lat, 0);
                run_gated(mk(1 << s, 7, 7, 1, 0), s, 1, s + 1, lat);
                chk(lat == s + 2, kind == 0 ? "R3" : "R6", lat, s + 2);
            end
        end

        // R4: none codes 6 and 7
        for (int c = 6; c < 8; c++) begin
            run_instr(mk(0, c, c, 0, 0), '0, lat);
            run_instr(mk(63, 7, 7, 0, 1), '0, lat);
            chk(lat == 1, "R4", lat, 1);
        end

        // R5: pending slot 5 outside mask does not block
        run_instr(mk(0, 7, 5, 0, 0), '0, lat);
        run_instr(mk(6'b011111, 7, 7, 0, 0), '0, lat);
        chk(lat == 0, "R5", lat, 0);
        run_gated(mk(6'b100000, 7, 7, 0, 0), 5, 1, 2, lat);
        chk(lat == 3, "R5", lat, 3);

        // R7: two claims need two completions
        run_instr(mk(0, 7, 4, 0, 0), '0, lat);
        run_instr(mk(0, 4, 7, 0, 0), '0, lat);
        run_gated(mk(6'b010000, 7, 7, 0, 0), 4, 2, 1, lat);
        chk(lat == 4, "R7", lat, 4);

        // R7: claim plus completion in same cycle cancel
        run_instr(mk(0, 7, 2, 0, 0), '0, lat);
        run_instr(mk(0, 7, 2, 0, 0), 6'b000100, lat);
        run_gated(mk(6'b000100, 7, 7, 0, 0), 2, 1, 3, lat);
        chk(lat == 4, "R7", lat, 4);

        // R8: completion on an idle slot flags an error for that cycle only
        @(negedge clk);
        done_pulse = 6'b001000;
        #1;
        chk(done_err == 1'b1, "R8", int'(done_err), 1);
        @(posedge clk);
        #1;
        done_pulse = '0;
        #1;
        chk(done_err == 1'b0, "R8", int'(done_err), 0);

        // R9: early completion never shortens the stall
        for (int st = 3; st < 16; st += 4) begin
            run_instr(mk(0, 7, 1, 0, 0), '0, lat);
            run_gated(mk(6'b000010, 7, 7, 0, st), 1, 1, 1, lat);
            exp = (st > 2) ? st : 2;
            chk(lat == exp, "R9", lat, exp);
        end
        // R9: late completion dominates
        run_instr(mk(0, 7, 0, 0, 0), '0, lat);
        run_gated(mk(6'b000001, 7, 7, 0, 2), 0, 1, 6, lat);
        chk(lat == 7, "R9", lat, 7);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule